// File: doc/BRIEF.md
# Operating-System Timer with Compare Channels and Watchdog

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on each cycle in which the tick-enable input is high. Four 32-bit compare channels watch the counter. When the counter steps onto a channel's compare value, the channel raises a status flag if its interrupt enable is set. Each status flag drives an interrupt line toward an external interrupt controller. Software clears a flag by writing a one to its bit.

The highest compare channel has a second role as a watchdog. Software arms the watchdog by writing a one to a dedicated register. The arm bit is sticky, and only the block's reset clears it. While the watchdog is armed, a step onto the channel-3 compare value raises a reset request toward the system reset generator. The request does not depend on that channel's interrupt enable. It stays high until the block itself is reset.

Software reaches every register through a simple single-cycle register bus. A write takes effect on the clock edge of the cycle in which it is presented. Read data is combinational from the selected word address.

Top module: `ostmr_top`

## Requirements
- R1: After reset, all eight registers read zero and every interrupt line and the reset request are low.
- R2: With tick enable high and no counter write, the counter rises by one per cycle and wraps from 0xFFFFFFFF to 0. With tick enable low, it holds its value.
- R3: A bus write to the counter (word 4) loads the written value and overrides a tick in the same cycle.
- R4: Word addresses 0 to 3 are compare channels 0 to 3, and word 7 is the interrupt-enable register (bit i for channel i). All of them read back what was written.
- R5: Status bit i sets only when a tick moves the counter onto compare value i while enable bit i is set. A disabled channel, or a counter write that lands on the compare value, does not set it.
- R6: Interrupt line i is high exactly while status bit i (status register, word 5) is set.
- R7: Writing a one to status bit i clears it, and writing a zero leaves it unchanged. A match in the same cycle as a clear leaves the bit set.
- R8: In the watchdog register (word 6), writing 1 to bit 0 arms it and writing 0 has no effect. Bits 31:1 always read zero, and only reset disarms it.
- R9: With the watchdog armed, a tick onto compare value 3 raises the reset request on that clock edge, regardless of interrupt enable 3. The request then stays high until reset.
- R10: With the watchdog not armed, a channel-3 match never raises the reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Counter advance enable |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 4 | Per-channel interrupt lines |
| resetReq | output | 1 | Latched watchdog reset request |

## Verification
The bench drives the counter to 0xFFFFFFFF and ticks it, which exposes a wrap that saturates or sticks. A disabled channel compared against 0 is watched across that wrap, so a design that ignores the enable raises a spurious flag. A clear and a new match are placed in the same cycle, and a design that lets the clear win loses an interrupt. A counter write and a tick are also placed in the same cycle, and a design that lets the tick win reads back one too many. A counter loaded directly onto a compare value is checked too, since a level comparator would flag it. The watchdog is tried before and after arming, along with zero-writes and upper-bit writes to its register. A disarmable, wide or non-sticky arm bit shows up in the read-back and in the reset request.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

  // Single-cycle strobes issued by the control to the datapath
  typedef struct packed {
    logic wrMatch;   // write to some compare register (index taken from address)
    logic wrCount;   // counter load
    logic wrStatus;  // write-one-to-clear on status flags
    logic wrWdog;    // write to the watchdog arm register
    logic wrIrqEn;   // write to interrupt enables
    logic step;      // counter advances this cycle
  } strobe_t;

endpackage

// File: rtl/ostmr_channel.sv
module ostmr_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrMatch,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] nextCount,
  input  logic              step,
  input  logic              clrFlag,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] matchQ,
  output logic              flagQ
);

  logic hit;

  // An equality event is only counted when the counter steps onto the value
  assign hit = step && (nextCount == matchQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      matchQ <= '0;
    end else if (wrMatch) begin
      matchQ <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= 1'b0;
    end else if (hit && irqEnable) begin
      flagQ <= 1'b1;          // a new match beats a simultaneous clear
    end else if (clrFlag) begin
      flagQ <= 1'b0;
    end
  end

endmodule

// File: rtl/ostmr_ctrl.sv
module ostmr_ctrl
  import ostmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              tickEn,
  input  logic              wdogHit,
  input  logic              wdogArmed,
  output strobe_t           strobe,
  output logic              resetReq
);

  localparam int CNT_IDX  = NUM_CH;
  localparam int STAT_IDX = NUM_CH + 1;
  localparam int WDOG_IDX = NUM_CH + 2;
  localparam int IEN_IDX  = NUM_CH + 3;

  logic wrAny;

  assign wrAny = busSel && busWrite;

  always_comb begin
    strobe          = '0;
    strobe.wrMatch  = wrAny && (busAddr < ADDR_W'(NUM_CH));
    strobe.wrCount  = wrAny && (busAddr == ADDR_W'(CNT_IDX));
    strobe.wrStatus = wrAny && (busAddr == ADDR_W'(STAT_IDX));
    strobe.wrWdog   = wrAny && (busAddr == ADDR_W'(WDOG_IDX));
    strobe.wrIrqEn  = wrAny && (busAddr == ADDR_W'(IEN_IDX));
    strobe.step     = tickEn && !strobe.wrCount;
  end

  // Reset request latches and is released only by the block reset
  always_ff @(posedge clk) begin
    if (rst) begin
      resetReq <= 1'b0;
    end else if (wdogArmed && wdogHit) begin
      resetReq <= 1'b1;
    end
  end

endmodule

// File: rtl/ostmr_datapath.sv
module ostmr_datapath
  import ostmr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] flagVec,
  output logic              wdogHit,
  output logic              wdogArmed
);

  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_IDX  = NUM_CH;
  localparam int STAT_IDX = NUM_CH + 1;
  localparam int WDOG_IDX = NUM_CH + 2;
  localparam int IEN_IDX  = NUM_CH + 3;

  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] nextCount;
  logic [NUM_CH-1:0] irqEnQ;
  logic [DATA_W-1:0] matchArr [NUM_CH];

  assign nextCount = countQ + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
    end else if (strobe.wrCount) begin
      countQ <= busWdata;
    end else if (strobe.step) begin
      countQ <= nextCount;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqEnQ <= '0;
    end else if (strobe.wrIrqEn) begin
      irqEnQ <= busWdata[NUM_CH-1:0];
    end
  end

  // Arm bit: set by a one in bit 0, never cleared by software
  always_ff @(posedge clk) begin
    if (rst) begin
      wdogArmed <= 1'b0;
    end else if (strobe.wrWdog && busWdata[0]) begin
      wdogArmed <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ostmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wrMatch   (strobe.wrMatch && (busAddr[CH_W-1:0] == CH_W'(g))),
      .wdata     (busWdata),
      .nextCount (nextCount),
      .step      (strobe.step),
      .clrFlag   (strobe.wrStatus && busWdata[g]),
      .irqEnable (irqEnQ[g]),
      .matchQ    (matchArr[g]),
      .flagQ     (flagVec[g])
    );
  end

  // Watchdog compare ignores the channel's interrupt enable
  assign wdogHit = strobe.step && (nextCount == matchArr[WDOG_CH]);

  always_comb begin
    busRdata = '0;
    if (busAddr < ADDR_W'(NUM_CH)) begin
      busRdata = matchArr[busAddr[CH_W-1:0]];
    end else if (busAddr == ADDR_W'(CNT_IDX)) begin
      busRdata = countQ;
    end else if (busAddr == ADDR_W'(STAT_IDX)) begin
      busRdata = {{(DATA_W-NUM_CH){1'b0}}, flagVec};
    end else if (busAddr == ADDR_W'(WDOG_IDX)) begin
      busRdata = {{(DATA_W-1){1'b0}}, wdogArmed};
    end else if (busAddr == ADDR_W'(IEN_IDX)) begin
      busRdata = {{(DATA_W-NUM_CH){1'b0}}, irqEnQ};
    end
  end

endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
  import ostmr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int WDOG_CH = NUM_CH - 1,
  parameter int ADDR_W  = $clog2(NUM_CH + 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic              resetReq
);

  strobe_t strobe;
  logic    wdogHit;
  logic    wdogArmed;

  ostmr_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .tickEn    (tickEn),
    .wdogHit   (wdogHit),
    .wdogArmed (wdogArmed),
    .strobe    (strobe),
    .resetReq  (resetReq)
  );

  ostmr_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WDOG_CH(WDOG_CH)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .flagVec   (irqOut),
    .wdogHit   (wdogHit),
    .wdogArmed (wdogArmed)
  );

endmodule

// File: rtl/ostmr_checker.sv
module ostmr_checker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tickEn,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [NUM_CH-1:0] irqOut,
  input logic              resetReq,
  input logic [DATA_W-1:0] countQ,
  input logic              wdogArmed,
  input logic [NUM_CH-1:0] irqEnQ
);

  logic cntWr, statWr, wdogWr;
  assign cntWr  = busSel && busWrite && (busAddr == ADDR_W'(NUM_CH));
  assign statWr = busSel && busWrite && (busAddr == ADDR_W'(NUM_CH + 1));
  assign wdogWr = busSel && busWrite && (busAddr == ADDR_W'(NUM_CH + 2));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tickEn && !cntWr) |=> (countQ == $past(countQ) + DATA_W'(1)));

  // R3
  count_load_chk: assert property (@(posedge clk) disable iff (rst)
    cntWr |=> (countQ == $past(busWdata)));

  // R5
  flag_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ((irqOut & ~$past(irqOut) & ~$past(irqEnQ)) == '0));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((~irqOut & $past(irqOut) & ~($past(statWr) ? $past(busWdata[NUM_CH-1:0]) : '0)) == '0));

  // R8
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wdogArmed |=> wdogArmed);

  // R8
  arm_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdogArmed) |-> $past(wdogWr && busWdata[0]));

  // R9
  reset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> resetReq);

  // R10
  reset_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(resetReq) |-> $past(wdogArmed));

endmodule

bind ostmr_top ostmr_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tickEn    (tickEn),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .irqOut    (irqOut),
  .resetReq  (resetReq),
  .countQ    (u_dp.countQ),
  .wdogArmed (u_dp.wdogArmed),
  .irqEnQ    (u_dp.irqEnQ)
);

// File: tb/ostmr_top_bench.sv
module ostmr_top_bench;

  localparam int A_CNT = 4;
  localparam int A_ST  = 5;
  localparam int A_WD  = 6;
  localparam int A_IE  = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irqOut;
  logic        resetReq;

  int checks = 0;
  int errors = 0;
  bit readPending = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  ostmr_top u_ostmr_top (
    .clk(clk), .rst(rst), .tickEn(tickEn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .resetReq(resetReq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item for each read cycle
  always @(negedge clk) begin
    if (readPending) begin
      if (expQ.size() == 0) begin
        check("scoreboard underrun", 32'h1, 32'h0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(it.tag, busRdata, it.exp);
      end
    end
  end

  task automatic idle(bit tick);
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0; tickEn = tick; readPending = 1'b0;
  endtask

  task automatic doWrite(int addr, logic [31:0] data, bit tick);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 3'(addr); busWdata = data;
    tickEn = tick; readPending = 1'b0;
  endtask

  task automatic doRead(int addr, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = 3'(addr); tickEn = 1'b0;
    expQ.push_back('{exp: exp, tag: tag});
    readPending = 1'b1;
  endtask

  task automatic pinCheck(string tag, logic [31:0] act, logic [31:0] exp);
    check(tag, act, exp);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 8; a++) doRead(a, 32'h0, "R1 register after reset");
    idle(0); @(negedge clk);
    pinCheck("R1 irq after reset", {28'h0, irqOut}, 32'h0);
    pinCheck("R1 resetReq after reset", {31'h0, resetReq}, 32'h0);

    // R4 compare and enable read-back
    doWrite(0, 32'h5, 0);
    doWrite(1, 32'h10, 0);
    doWrite(2, 32'h0, 0);
    doWrite(3, 32'h200, 0);
    doWrite(A_IE, 32'h3, 0);
    doRead(0, 32'h5, "R4 match0");
    doRead(1, 32'h10, "R4 match1");
    doRead(2, 32'h0, "R4 match2");
    doRead(3, 32'h200, "R4 match3");
    doRead(A_IE, 32'h3, "R4 irq enable");

    // R3 load, R2 hold and step, R5/R6 match
    doWrite(A_CNT, 32'h3, 0);
    doRead(A_CNT, 32'h3, "R3 counter load");
    idle(0); idle(0); idle(0);
    doRead(A_CNT, 32'h3, "R2 hold without tick");
    idle(1); idle(1);
    doRead(A_CNT, 32'h5, "R2 two ticks");
    doRead(A_ST, 32'h1, "R5 ch0 flag on step");
    idle(0); @(negedge clk);
    pinCheck("R6 irq follows flag", {28'h0, irqOut}, 32'h1);

    // R3 write beats tick
    doWrite(A_CNT, 32'd100, 1);
    doRead(A_CNT, 32'd100, "R3 write over tick");

    // R2 wrap; R5 disabled ch2 matches 0 but stays clear
    doWrite(A_CNT, 32'hFFFF_FFFF, 0);
    idle(1);
    doRead(A_CNT, 32'h0, "R2 wrap to zero");
    doRead(A_ST, 32'h1, "R5 disabled channel no flag");

    // R5 counter load onto compare value
    doWrite(A_CNT, 32'h10, 0);
    doRead(A_ST, 32'h1, "R5 load onto match no flag");

    // R7 write-one-to-clear
    doWrite(A_ST, 32'h0, 0);
    doRead(A_ST, 32'h1, "R7 zero write no effect");
    doWrite(A_ST, 32'h1, 0);
    doRead(A_ST, 32'h0, "R7 one clears");
    idle(0); @(negedge clk);
    pinCheck("R6 irq low after clear", {28'h0, irqOut}, 32'h0);
    doWrite(A_CNT, 32'h0F, 0);
    doWrite(A_ST, 32'h2, 1);
    doRead(A_ST, 32'h2, "R7 set wins over clear");
    doWrite(A_ST, 32'h2, 0);
    doRead(A_ST, 32'h0, "R7 clear ch1");

    // R8 upper bits ignored
    doRead(A_WD, 32'h0, "R8 unarmed");
    doWrite(A_WD, 32'hFFFF_FFFE, 0);
    doRead(A_WD, 32'h0, "R8 upper bits never set");

    // R10 unarmed ch3 match
    doWrite(A_CNT, 32'h1FF, 0);
    idle(1); idle(0); @(negedge clk);
    pinCheck("R10 no reset request unarmed", {31'h0, resetReq}, 32'h0);
    doRead(A_ST, 32'h0, "R5 ch3 disabled no flag");

    // R8 arm sticky
    doWrite(A_WD, 32'h1, 0);
    doRead(A_WD, 32'h1, "R8 armed");
    doWrite(A_WD, 32'h0, 0);
    doRead(A_WD, 32'h1, "R8 zero write keeps arm");

    // R9 armed ch3 match
    doWrite(A_CNT, 32'h1FF, 0);
    idle(1); idle(0); @(negedge clk);
    pinCheck("R9 reset request raised", {31'h0, resetReq}, 32'h1);
    idle(0); idle(0); idle(0); @(negedge clk);
    pinCheck("R9 reset request held", {31'h0, resetReq}, 32'h1);
    doRead(A_ST, 32'h0, "R9 independent of irq enable");

    // R1 reset clears arm and request
    idle(0);
    rst = 1'b1;
    idle(0); idle(0);
    #0 rst = 1'b0;
    doRead(A_WD, 32'h0, "R1 arm cleared by reset");
    doRead(A_CNT, 32'h0, "R1 counter cleared by reset");
    idle(0); @(negedge clk);
    pinCheck("R1 resetReq cleared by reset", {31'h0, resetReq}, 32'h0);

    idle(0); idle(0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule